// File: doc/BRIEF.md
# Dual-Supply Undervoltage Lockout

This block watches two supply rails of a half-bridge gate driver: the control rail that also feeds the low-side output stage, and the floating rail that feeds the high-side stage. Each rail arrives as a sampled, unsigned voltage code. The code scale is 10 mV per LSB, and every threshold comparison works on the codes directly. For each rail the block keeps a ready state. It has a turn-on level and a lower turn-off level, so the two levels form a hysteresis band. A persistence filter keeps short dips below the turn-off level from shutting a rail down. A fixed hard floor at 7.5 V (code 750) shuts a rail down on the next clock, whatever the filter holds.

The two rails gate the outputs differently. When the control rail is not ready, both output sections are blocked. When the floating rail is not ready, only the high side is blocked. A combined undervoltage flag goes to the fault-pin logic. A static select input chooses between two threshold sets: one for IGBT switches and one for MOSFET switches. The select also picks the filter length. It may change only while reset is held.

Top module: `uvlo_dual`

## Requirements
- R1: While reset is asserted, and right after it, both rails are not ready: `ls_en`=0, `hs_en`=0 and `uv_flag`=1.
- R2: A control rail that is not ready becomes ready at the first clock edge that samples `vctl_code` at or above its turn-on code: 1250 when `mos_sel`=0, 910 when `mos_sel`=1. The result shows on `ls_en` after that edge.
- R3: A floating rail that is not ready becomes ready at the first edge that samples `vhs_code` at or above its turn-on code: 1160 when `mos_sel`=0, 910 when `mos_sel`=1.
- R4: A ready rail stays ready while its code is at or above its turn-off code. The turn-off codes are 1160 (control) and 1070 (floating) when `mos_sel`=0, and 830 for both rails when `mos_sel`=1.
- R5: A ready rail whose code is at or above 750 but below its turn-off code drops out at the edge that takes the FILT-th consecutive such sample. FILT is `FILT_IGBT` when `mos_sel`=0 and `FILT_MOS` when `mos_sel`=1. With fewer consecutive samples the rail stays ready.
- R6: A single sample at or above the turn-off code restarts the persistence count from zero.
- R7: A sample below 750 makes that rail not ready at the same edge, whatever the filter count.
- R8: `ls_en` follows the control rail's ready state. `hs_en` is high only when both rails are ready. A floating-rail fault leaves `ls_en` unchanged.
- R9: `uv_flag` is 1 whenever either rail is not ready, and 0 otherwise.
- R10: A rail that is not ready stays not ready for any code below its turn-on code, including codes inside the hysteresis band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mos_sel | input | 1 | 0 selects the IGBT threshold set, 1 the MOSFET set; static outside reset |
| vctl_code | input | 11 | Control rail code, 10 mV per LSB |
| vhs_code | input | 11 | Floating rail code, 10 mV per LSB |
| ls_en | output | 1 | Low-side output section allowed |
| hs_en | output | 1 | High-side output section allowed |
| uv_flag | output | 1 | Either rail in undervoltage |

## Verification
Each rail is swept upward through its turn-on level, then downward through the hysteresis band in slow steps, under both threshold sets. These sweeps separate the turn-on edge from the turn-off edge and locate each boundary to the exact code. Dips below the turn-off level, lasting one sample less than the filter length and exactly the filter length, tell a correct persistence count from an off-by-one count. A dip split by a single good sample shows that the count restarts. One-sample drops under the hard floor on each rail, and a long fault on the floating rail alone, show that the floor bypasses the filter and that the two rails gate the outputs asymmetrically.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
    localparam int unsigned UV_CODE_W = 11;
    localparam int unsigned UV_NUM_SUP = 2;

    typedef logic [UV_CODE_W-1:0] uv_code_t;

    typedef struct packed {
        uv_code_t on_th;
        uv_code_t off_th;
    } uv_thr_t;

    typedef enum logic {
        SUP_CTL = 1'b0,
        SUP_HS  = 1'b1
    } uv_sup_e;
endpackage

// File: rtl/uvlo_thr_sel.sv
module uvlo_thr_sel
    import uvlo_pkg::*;
#(
    parameter int unsigned CNT_W        = 9,
    parameter int unsigned FILT_IGBT    = 375,
    parameter int unsigned FILT_MOS     = 38,
    parameter int unsigned CTL_ON_IGBT  = 1250,
    parameter int unsigned CTL_OFF_IGBT = 1160,
    parameter int unsigned HS_ON_IGBT   = 1160,
    parameter int unsigned HS_OFF_IGBT  = 1070,
    parameter int unsigned ON_MOS       = 910,
    parameter int unsigned OFF_MOS      = 830
) (
    input  logic                          mos_sel,
    output uv_thr_t [UV_NUM_SUP-1:0]      thr_o,
    output logic    [CNT_W-1:0]           filt_len_o
);
    localparam int IDX_CTL = int'(SUP_CTL);
    localparam int IDX_HS  = int'(SUP_HS);

    always_comb begin
        if (mos_sel) begin
            thr_o[IDX_CTL].on_th  = uv_code_t'(ON_MOS);
            thr_o[IDX_CTL].off_th = uv_code_t'(OFF_MOS);
            thr_o[IDX_HS].on_th   = uv_code_t'(ON_MOS);
            thr_o[IDX_HS].off_th  = uv_code_t'(OFF_MOS);
            filt_len_o            = CNT_W'(FILT_MOS);
        end else begin
            thr_o[IDX_CTL].on_th  = uv_code_t'(CTL_ON_IGBT);
            thr_o[IDX_CTL].off_th = uv_code_t'(CTL_OFF_IGBT);
            thr_o[IDX_HS].on_th   = uv_code_t'(HS_ON_IGBT);
            thr_o[IDX_HS].off_th  = uv_code_t'(HS_OFF_IGBT);
            filt_len_o            = CNT_W'(FILT_IGBT);
        end
    end
endmodule

// File: rtl/uvlo_chan.sv
module uvlo_chan
    import uvlo_pkg::*;
#(
    parameter int unsigned CNT_W      = 9,
    parameter int unsigned FLOOR_CODE = 750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  uv_code_t         code_i,
    input  uv_thr_t          thr_i,
    input  logic [CNT_W-1:0] filt_len_i,
    output logic             ready_o
);
    typedef struct packed {
        logic             ready;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    localparam uv_code_t FLOOR_TH = uv_code_t'(FLOOR_CODE);

    chan_st_t         st_d, st_q;
    logic [CNT_W-1:0] filt_last;

    assign filt_last = filt_len_i - 1'b1;

    always_comb begin
        st_d = st_q;
        if (code_i < FLOOR_TH) begin
            // hard floor: no filtering
            st_d.ready = 1'b0;
            st_d.cnt   = '0;
        end else if (!st_q.ready) begin
            st_d.cnt = '0;
            if (code_i >= thr_i.on_th) begin
                st_d.ready = 1'b1;
            end
        end else if (code_i < thr_i.off_th) begin
            if (st_q.cnt >= filt_last) begin
                st_d.ready = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.ready;
endmodule

// File: rtl/uvlo_dual.sv
module uvlo_dual
    import uvlo_pkg::*;
#(
    parameter int unsigned FILT_IGBT    = 375,
    parameter int unsigned FILT_MOS     = 38,
    parameter int unsigned CTL_ON_IGBT  = 1250,
    parameter int unsigned CTL_OFF_IGBT = 1160,
    parameter int unsigned HS_ON_IGBT   = 1160,
    parameter int unsigned HS_OFF_IGBT  = 1070,
    parameter int unsigned ON_MOS       = 910,
    parameter int unsigned OFF_MOS      = 830,
    parameter int unsigned FLOOR_CODE   = 750
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mos_sel,
    input  logic [10:0] vctl_code,
    input  logic [10:0] vhs_code,
    output logic        ls_en,
    output logic        hs_en,
    output logic        uv_flag
);
    localparam int unsigned FILT_MAX = (FILT_IGBT > FILT_MOS) ? FILT_IGBT : FILT_MOS;
    localparam int unsigned CNT_W    = $clog2(FILT_MAX + 1);
    localparam int IDX_CTL = int'(SUP_CTL);
    localparam int IDX_HS  = int'(SUP_HS);

    uv_code_t [UV_NUM_SUP-1:0] code_w;
    uv_thr_t  [UV_NUM_SUP-1:0] thr_w;
    logic     [CNT_W-1:0]      filt_len_w;
    logic     [UV_NUM_SUP-1:0] rdy_w;

    assign code_w[IDX_CTL] = vctl_code;
    assign code_w[IDX_HS]  = vhs_code;

    uvlo_thr_sel #(
        .CNT_W        (CNT_W),
        .FILT_IGBT    (FILT_IGBT),
        .FILT_MOS     (FILT_MOS),
        .CTL_ON_IGBT  (CTL_ON_IGBT),
        .CTL_OFF_IGBT (CTL_OFF_IGBT),
        .HS_ON_IGBT   (HS_ON_IGBT),
        .HS_OFF_IGBT  (HS_OFF_IGBT),
        .ON_MOS       (ON_MOS),
        .OFF_MOS      (OFF_MOS)
    ) u_thr_sel (
        .mos_sel    (mos_sel),
        .thr_o      (thr_w),
        .filt_len_o (filt_len_w)
    );

    for (genvar g = 0; g < UV_NUM_SUP; g++) begin : g_chan
        uvlo_chan #(
            .CNT_W      (CNT_W),
            .FLOOR_CODE (FLOOR_CODE)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .code_i     (code_w[g]),
            .thr_i      (thr_w[g]),
            .filt_len_i (filt_len_w),
            .ready_o    (rdy_w[g])
        );
    end

    // control rail gates both sections, floating rail only the high side
    assign ls_en   = rdy_w[IDX_CTL];
    assign hs_en   = rdy_w[IDX_CTL] & rdy_w[IDX_HS];
    assign uv_flag = ~(&rdy_w);
endmodule

// File: rtl/uvlo_dual_chk.sv
module uvlo_dual_chk
    import uvlo_pkg::*;
#(
    parameter int unsigned CTL_ON_IGBT  = 1250,
    parameter int unsigned CTL_OFF_IGBT = 1160,
    parameter int unsigned HS_ON_IGBT   = 1160,
    parameter int unsigned ON_MOS       = 910,
    parameter int unsigned OFF_MOS      = 830,
    parameter int unsigned FLOOR_CODE   = 750
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mos_sel,
    input logic [10:0] vctl_code,
    input logic [10:0] vhs_code,
    input logic        ls_en,
    input logic        hs_en,
    input logic        uv_flag
);
    uv_code_t ctl_on, ctl_off, hs_on;

    assign ctl_on  = mos_sel ? uv_code_t'(ON_MOS)  : uv_code_t'(CTL_ON_IGBT);
    assign ctl_off = mos_sel ? uv_code_t'(OFF_MOS) : uv_code_t'(CTL_OFF_IGBT);
    assign hs_on   = mos_sel ? uv_code_t'(ON_MOS)  : uv_code_t'(HS_ON_IGBT);

    assert_ctl_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> ($past(vctl_code) >= $past(ctl_on)));

    assert_hs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_en) && $past(ls_en)) |-> ($past(vhs_code) >= $past(hs_on)));

    assert_hold_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && vctl_code >= ctl_off) |=> ls_en);

    assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vctl_code < uv_code_t'(FLOOR_CODE)) |=> (!ls_en && !hs_en));

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_en |-> !hs_en);

    assert_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_en || !hs_en) |-> uv_flag);

    assert_no_early_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_en && vctl_code < ctl_on) |=> !ls_en);
endmodule

bind uvlo_dual uvlo_dual_chk #(
    .CTL_ON_IGBT  (CTL_ON_IGBT),
    .CTL_OFF_IGBT (CTL_OFF_IGBT),
    .HS_ON_IGBT   (HS_ON_IGBT),
    .ON_MOS       (ON_MOS),
    .OFF_MOS      (OFF_MOS),
    .FLOOR_CODE   (FLOOR_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mos_sel   (mos_sel),
    .vctl_code (vctl_code),
    .vhs_code  (vhs_code),
    .ls_en     (ls_en),
    .hs_en     (hs_en),
    .uv_flag   (uv_flag)
);

// File: tb/uvlo_dual_bench.sv
module uvlo_dual_bench;
    localparam int FI = 12;
    localparam int FM = 5;
    localparam int FLOOR = 750;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mos_sel = 1'b0;
    logic [10:0] vc = '0;
    logic [10:0] vh = '0;
    logic        ls_en, hs_en, uv_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference state
    bit m_rdy [2];
    int m_cnt [2];

    always #2 clk = ~clk;

    uvlo_dual #(.FILT_IGBT(FI), .FILT_MOS(FM)) u_uvlo_dual (
        .clk(clk), .rst_n(rst_n), .mos_sel(mos_sel),
        .vctl_code(vc), .vhs_code(vh),
        .ls_en(ls_en), .hs_en(hs_en), .uv_flag(uv_flag)
    );

    function automatic int f_len();
        return mos_sel ? FM : FI;
    endfunction

    function automatic int on_of(int ch);
        if (mos_sel) return 910;
        return (ch == 0) ? 1250 : 1160;
    endfunction

    function automatic int off_of(int ch);
        if (mos_sel) return 830;
        return (ch == 0) ? 1160 : 1070;
    endfunction

    task automatic model_step();
        for (int ch = 0; ch < 2; ch++) begin
            int v;
            v = (ch == 0) ? int'(vc) : int'(vh);
            if (!rst_n || v < FLOOR) begin
                m_rdy[ch] = 1'b0; m_cnt[ch] = 0;
            end else if (!m_rdy[ch]) begin
                m_cnt[ch] = 0;
                if (v >= on_of(ch)) m_rdy[ch] = 1'b1;
            end else if (v < off_of(ch)) begin
                if (m_cnt[ch] == f_len() - 1) begin
                    m_rdy[ch] = 1'b0; m_cnt[ch] = 0;
                end else begin
                    m_cnt[ch] = m_cnt[ch] + 1;
                end
            end else begin
                m_cnt[ch] = 0;
            end
        end
    endtask

    task automatic check_out();
        logic e_ls, e_hs, e_uv;
        e_ls = m_rdy[0];
        e_hs = m_rdy[0] & m_rdy[1];
        e_uv = ~(m_rdy[0] & m_rdy[1]);
        checks++;
        if (ls_en !== e_ls || hs_en !== e_hs || uv_flag !== e_uv) begin
            errors++;
            $display("FAIL %s mode=%0d vc=%0d vh=%0d ls/hs/uv actual %b%b%b expected %b%b%b",
                     cur_req, mos_sel, vc, vh, ls_en, hs_en, uv_flag, e_ls, e_hs, e_uv);
        end
    endtask

    // inputs change 1 ns after a rising edge; outputs checked 1 ns after the next
    task automatic step(int c, int h, int n = 1);
        for (int i = 0; i < n; i++) begin
            vc = 11'(c);
            vh = 11'(h);
            @(posedge clk);
            model_step();
            #1;
            check_out();
        end
    endtask

    task automatic do_reset(bit mode);
        cur_req = "R1";
        rst_n = 1'b0;
        mos_sel = mode;
        step(1400, 1400, 3);
        rst_n = 1'b1;
        step(0, 0, 1);
    endtask

    task automatic run_mode(bit mode);
        int F, coff, con, hoff;
        do_reset(mode);
        F = f_len();
        coff = off_of(0); con = on_of(0); hoff = off_of(1);

        cur_req = "R2";  // control rail turn-on sweep, floating rail down
        for (int v = 0; v <= 1400; v += 10) step(v, 0);
        step(con - 1, 0, 2);

        cur_req = "R3";  // floating rail turn-on sweep, control rail up
        for (int v = 0; v <= 1400; v += 10) step(1400, v);

        cur_req = "R4";  // slow walk down to the turn-off code and back
        for (int v = 1400; v >= coff; v -= 10) step(v, 1400, 3);
        step(coff, 1400, F + 3);
        step(1400, 1400, 2);

        cur_req = "R5";  // dip one short of the filter, then exactly the filter
        step(coff - 1, 1400, F - 1);
        step(1400, 1400, 2);
        step(coff - 1, 1400, F);
        step(coff - 1, 1400, 2);

        cur_req = "R10"; // band between off and on does not re-arm
        for (int v = coff; v < con; v += 5) step(v, 1400);
        step(con - 1, 1400, 3);
        step(con, 1400, 2);

        cur_req = "R6";  // dip split by one good sample restarts the count
        step(coff - 1, 1400, F - 1);
        step(coff, 1400, 1);
        step(coff - 1, 1400, F - 1);
        step(1400, 1400, 2);

        cur_req = "R7";  // single-sample hard-floor hits on each rail
        step(FLOOR - 1, 1400, 1);
        step(FLOOR, 1400, 2);
        step(1400, 1400, 2);
        step(1400, FLOOR - 1, 1);
        step(1400, 1400, 2);

        cur_req = "R8";  // floating-rail fault only blocks the high side
        step(1400, hoff - 1, F + 2);
        step(1400, 1400, 2);

        cur_req = "R9";  // fine falling ramp on both rails through every level
        for (int v = 1400; v >= 600; v -= 2) step(v, v);
        for (int v = 600; v <= 1400; v += 3) step(v, 1400 - (v - 600) / 2);
    endtask

    initial begin
        m_rdy[0] = 1'b0; m_rdy[1] = 1'b0;
        m_cnt[0] = 0; m_cnt[1] = 0;
        run_mode(1'b0);
        run_mode(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #700000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule